// File: doc/BRIEF.md
# Inverting-Operand 32-bit ALU

A purely combinational arithmetic/logic unit for a single-cycle processor datapath. It takes two operands and a 4-bit control code and returns a result word together with a flag that is high whenever that word is all zeros. A branch unit uses the flag to decide whether two registers compared equal.

The control code is a bit field, not an opcode. The top bit complements operand A. The next bit complements operand B. The low two bits pick the AND result, the OR result, the adder sum or the less-than bit. The adder carry-in is tied to the B-complement bit, so complementing B turns the adder into a two's-complement subtractor. Signed comparison is taken from that same subtraction. Only six codes are defined. Every other code yields a zero word.

Top module: `inv_alu32`

## Requirements
- R1: Control 4'b0000 drives the result to the bitwise AND of the two operands.
- R2: Control 4'b0001 drives the result to the bitwise OR of the two operands.
- R3: Control 4'b0010 drives the result to the sum of the operands modulo 2^32, with the carry out discarded.
- R4: Control 4'b0110 drives the result to operand A minus operand B modulo 2^32.
- R5: Control 4'b0111 drives result bit 0 to 1 exactly when A is less than B as signed two's-complement values, also when A minus B overflows. Result bits 31:1 are 0.
- R6: Control 4'b1100 (both operands complemented, AND selected) drives the result to the bitwise NOR of the operands.
- R7: Every other control value (0011, 0100, 0101, 1000 to 1011, 1101 to 1111) drives a result of all zeros.
- R8: The zero output is 1 exactly when all 32 result bits are 0, for every control code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| alu_ctl | input | 4 | Bit 3 complements A, bit 2 complements B, bits 1:0 select AND/OR/sum/less-than |
| alu_out | output | 32 | Result word |
| is_zero | output | 1 | High when alu_out is all zeros |

## Verification
The result and the zero flag are produced together, and the interesting cases are those where an arithmetic or comparison result lands exactly on zero. These cases are forced directly: subtraction of equal operands, an addition that wraps to zero, a less-than test that comes out false, and every undefined code. Random operand and code pairs fill in the remaining space. In each case the bench compares the word and the flag against a model built from the requirements, using native signed comparison rather than the adder-sign method.

// File: rtl/inv_alu32.sv
module inv_alu32 #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       alu_ctl,
  output logic [WIDTH-1:0] alu_out,
  output logic             is_zero
);
  localparam int MSB = WIDTH - 1;

  logic             inv_a, inv_b;
  logic [1:0]       pick;
  logic [WIDTH-1:0] xa, xb, sum;
  logic             ovf, less, legal;

  assign inv_a = alu_ctl[3];
  assign inv_b = alu_ctl[2];
  assign pick  = alu_ctl[1:0];

  assign xa  = inv_a ? ~op_a : op_a;
  assign xb  = inv_b ? ~op_b : op_b;
  assign sum = xa + xb + {{(WIDTH-1){1'b0}}, inv_b};

  assign ovf  = (xa[MSB] == xb[MSB]) && (sum[MSB] != xa[MSB]);
  assign less = sum[MSB] ^ ovf;

  always_comb begin
    unique case (alu_ctl)
      4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    alu_out = '0;
    if (legal) begin
      unique case (pick)
        2'b00: alu_out = xa & xb;
        2'b01: alu_out = xa | xb;
        2'b10: alu_out = sum;
        2'b11: alu_out = {{(WIDTH-1){1'b0}}, less};
      endcase
    end
  end

  assign is_zero = ~|alu_out;

  always_comb begin
    if (alu_ctl == 4'b0000)
      assert_and_R1: assert (alu_out == (op_a & op_b));
    if (alu_ctl == 4'b0010)
      assert_add_R3: assert (alu_out == op_a + op_b);
    if (alu_ctl == 4'b0110) begin
      assert_sub_R4: assert (alu_out == op_a - op_b);
      assert_eq_zero_R8: assert (is_zero == (op_a == op_b));
    end
    if (alu_ctl == 4'b0111)
      assert_slt_R5: assert (alu_out == {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))});
    if (alu_ctl == 4'b1100)
      assert_nor_R6: assert (alu_out == ~(op_a | op_b));
    if (!legal)
      assert_undef_R7: assert (is_zero);
  end
endmodule

// File: tb/inv_alu32_tb.sv
module inv_alu32_tb;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  alu_ctl = '0;
  logic [31:0] alu_out;
  logic        is_zero;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  inv_alu32 u_dut (.op_a(op_a), .op_b(op_b), .alu_ctl(alu_ctl),
                   .alu_out(alu_out), .is_zero(is_zero));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] c);
    case (c)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return {31'd0, ($signed(a) < $signed(b))};
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    logic [31:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; alu_ctl = c;
    @(posedge clk); #1;
    exp = model(a, b, c);
    n_chk++;
    if (alu_out !== exp) begin
      n_bad++;
      $display("FAIL %s ctl=%b a=%h b=%h actual=%h expected=%h", tag_of(c), c, a, b, alu_out, exp);
    end
    n_chk++;
    if (is_zero !== (exp == 32'd0)) begin
      n_bad++;
      $display("FAIL R8 ctl=%b a=%h b=%h actual=%b expected=%b", c, a, b, is_zero, exp == 32'd0);
    end
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    run(32'h0, 32'h0, 4'b0000);                    // R1 idle inputs, R8 flag high
    run(32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0000);    // R1
    run(32'hF000_0000, 32'h0000_000F, 4'b0001);    // R2
    run(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);    // R3 wrap to zero, R8
    run(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);    // R3
    run(32'h1234_5678, 32'h1234_5678, 4'b0110);    // R4 equal, R8
    run(32'h0000_0000, 32'h0000_0001, 4'b0110);    // R4 borrow
    run(32'h8000_0000, 32'h0000_0001, 4'b0111);    // R5 overflow case -> 1
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);    // R5 overflow case -> 0
    run(32'hFFFF_FFFF, 32'h0000_0000, 4'b0111);    // R5 -1 < 0
    run(32'h0000_0005, 32'h0000_0005, 4'b0111);    // R5 equal -> 0, R8
    run(32'h00FF_0000, 32'h0000_00FF, 4'b1100);    // R6
    run(32'h0, 32'h0, 4'b1100);                    // R6 all ones
    for (int c = 0; c < 16; c++)
      run(32'hDEAD_BEEF, 32'h0BAD_F00D, 4'(c));    // R7 undefined codes give zero
    for (int i = 0; i < 3000; i++)
      run($urandom, (i % 7 == 0) ? 32'h0 : $urandom, 4'($urandom_range(0, 15)));
    for (int i = 0; i < 200; i++) begin
      logic [31:0] v;
      v = $urandom;
      run(v, v, 4'b0110);                          // R4 / R8 equal operands
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule